// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block connects an 8-bit host processor to a small on-chip register file. One static select input chooses the bus style. With the select low, the host sends a register address and the data over the same 8-bit bus, and a rising address strobe captures the address. With the select high, the host presents the register number on a dedicated 5-bit address input, the 8-bit bus carries only data, and the strobe is ignored. In both styles every access is qualified by an active-low chip select, and reads and writes use active-low strobes.

The register file holds a parameterised set of read/write control registers, an interrupt mask and a sticky event status register that clears on read. An active-low interrupt output, meant to enable an open-drain pad pull-down, asserts while any status bit is set under an enabled mask bit. A small bus-cycle state machine tracks each access. It has three states: `BS_IDLE`, `BS_READ` and `BS_WRITE`. Its transitions are IDLE→WRITE when chip select and write are both low, and IDLE→READ when chip select and read are both low with write high. WRITE→IDLE on commit happens when the write strobe rises while chip select is still low. WRITE→IDLE on abort happens when chip select rises before the write strobe does. READ→IDLE on release happens when either the read strobe or chip select goes high, and this transition also issues the status clear.

Top module: `hbi_host_port`

## Requirements
- R1: With `mode_sep`=1 the register number comes from `addr_in`, and pulses on `as` change nothing: neither the register that is selected nor the data that is read back.
- R2: With `mode_sep`=0 the address is captured from `bus_in` in the first clock in which `as` is seen high after being low. Only bits [4:0] of the captured value select a register, so 0xE2 and 0x02 reach the same register.
- R3: A write takes effect in the clock in which `wr_n` is seen high again after a low phase, provided `cs_n` is still low. The data written is the last `bus_in` value sampled while `cs_n` and `wr_n` were both low. If `cs_n` rises before `wr_n`, the write is dropped. A `wr_n` pulse with `cs_n` high writes nothing.
- R4: `bus_oe` is high only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. While it is high, `bus_out` carries the addressed register.
- R5: While `rst_n` is low, all control registers, the mask and the status are held at zero, `irq_n` is 1 and `ctrl_q` is 0.
- R6: The register map is as follows. Addresses 0..3 are control registers (read/write), and they appear on `ctrl_q` with register k at bits [8k+7:8k]. Address 4 is the interrupt mask (read/write). Address 5 is the status register, which is read-only. Every other address reads 0, and writes to it are ignored.
- R7: A status bit is set in any clock in which the matching `evt_in` bit is high, and it stays set until it is cleared by a read.
- R8: When a read of address 5 ends, the status bits that were shown on the bus are cleared. An event that arrives in the clearing clock keeps its bit set.
- R9: `irq_n` is 0 exactly when (status AND mask) is nonzero. It follows register changes with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mode_sep | input | 1 | Bus style: 0 shared address/data, 1 separate address |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| as | input | 1 | Address strobe, used only when mode_sep is 0 |
| addr_in | input | 5 | Register number when mode_sep is 1 |
| bus_in | input | 8 | Data bus (and address in shared mode) seen from the pad |
| bus_out | output | 8 | Read data toward the pad |
| bus_oe | output | 1 | Pad output enable for the data bus |
| evt_in | input | 8 | Status event inputs, one per status bit |
| ctrl_q | output | 32 | Control registers 0..3, concatenated |
| irq_n | output | 1 | Active-low interrupt; drives the open-drain pull-down |

## Verification
The bench builds the block with its defaults: 8-bit data, a 5-bit address, four control registers and eight event bits. With these values the mask lands at address 4 and the status at address 5. It also leaves addresses 6 to 31 unused, so the bench can probe reads of unused locations (for example 0x14 and 0x1F) and shared-bus addresses whose upper three bits are set. Eight event bits, with a mask that enables only the low nibble, allow an event on a masked bit and an unmasked one to be compared within the same run.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_READ  = 2'd1,
        BS_WRITE = 2'd2
    } bus_state_e;
endpackage

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sep,
    input  logic              as,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr
);
    logic              as_q;
    logic [ADDR_W-1:0] lat_q;
    logic              as_rise;

    assign as_rise = as && !as_q && !mode_sep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q  <= 1'b0;
            lat_q <= '0;
        end else begin
            as_q <= as;
            if (as_rise) begin
                lat_q <= bus_in[ADDR_W-1:0];
            end
        end
    end

    assign eff_addr = mode_sep ? addr_in : lat_q;
endmodule

// File: rtl/hbi_bus_fsm.sv
module hbi_bus_fsm
    import hbi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [ADDR_W-1:0] eff_addr,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_active,
    output logic              rd_release,
    output logic              bus_oe
);
    bus_state_e state_q, state_d;
    logic       wr_active;

    assign wr_active = !cs_n && !wr_n;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: begin
                if (wr_active)                       state_d = BS_WRITE;
                else if (!cs_n && !rd_n)             state_d = BS_READ;
            end
            BS_WRITE: begin
                if (cs_n || wr_n)                    state_d = BS_IDLE;
            end
            BS_READ: begin
                if (cs_n || rd_n)                    state_d = BS_IDLE;
            end
            default:                                 state_d = BS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    // write capture: last sample taken while the strobe was active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (wr_active) begin
            wr_addr <= eff_addr;
            wr_data <= bus_in;
        end
    end

    // outputs
    always_comb begin
        wr_commit  = 1'b0;
        rd_release = 1'b0;
        unique case (state_q)
            BS_WRITE: wr_commit  = !cs_n && wr_n;
            BS_READ:  rd_release = cs_n || rd_n;
            default: ;
        endcase
        rd_active = !cs_n && !rd_n && wr_n;
        bus_oe    = rd_active && rst_n;
    end
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int N_CTRL = 4,
    parameter int EVT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_commit,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_active,
    input  logic                     rd_release,
    input  logic [EVT_W-1:0]         evt_in,
    output logic [DATA_W-1:0]        rd_data,
    output logic [N_CTRL*DATA_W-1:0] ctrl_q,
    output logic                     irq_n
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(N_CTRL);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(N_CTRL + 1);

    logic [EVT_W-1:0] mask_q, stat_q, snap_q;

    genvar g;
    generate
        for (g = 0; g < N_CTRL; g++) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctrl_q[g*DATA_W +: DATA_W] <= '0;
                end else if (wr_commit && wr_addr == ADDR_W'(g)) begin
                    ctrl_q[g*DATA_W +: DATA_W] <= wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_commit && wr_addr == MASK_A) begin
            mask_q <= wr_data[EVT_W-1:0];
        end
    end

    // snapshot of what the host saw during the read of the status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_active) begin
            snap_q <= (rd_addr == STAT_A) ? stat_q : '0;
        end else if (rd_release) begin
            snap_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (rd_release ? (stat_q & ~snap_q) : stat_q) | evt_in;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_CTRL; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = ctrl_q[i*DATA_W +: DATA_W];
        end
        if (rd_addr == MASK_A) rd_data = DATA_W'(mask_q);
        if (rd_addr == STAT_A) rd_data = DATA_W'(stat_q);
    end

    assign irq_n = ~|(stat_q & mask_q);
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int N_CTRL = 4,
    parameter int EVT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_sep,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic                     as,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic [DATA_W-1:0]        bus_in,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    input  logic [EVT_W-1:0]         evt_in,
    output logic [N_CTRL*DATA_W-1:0] ctrl_q,
    output logic                     irq_n
);
    logic [ADDR_W-1:0] eff_addr, wr_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              wr_commit, rd_active, rd_release;

    hbi_addr_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .as(as),
        .bus_in(bus_in), .addr_in(addr_in), .eff_addr(eff_addr)
    );

    hbi_bus_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .eff_addr(eff_addr), .wr_commit(wr_commit),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_active(rd_active),
        .rd_release(rd_release), .bus_oe(bus_oe)
    );

    hbi_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .EVT_W(EVT_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(eff_addr), .rd_active(rd_active),
        .rd_release(rd_release), .evt_in(evt_in), .rd_data(rd_data),
        .ctrl_q(ctrl_q), .irq_n(irq_n)
    );

    assign bus_out = bus_oe ? rd_data : '0;
endmodule

// File: rtl/hbi_host_port_chk.sv
module hbi_host_port_chk #(
    parameter int CTRL_W = 32,
    parameter int EVT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              bus_oe,
    input logic [EVT_W-1:0]  evt_in,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              irq_n
);
    // R4: no drive unless selected and reading
    a_r4_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n || !wr_n) |-> !bus_oe);

    // R5: reset holds control outputs clear and interrupt released
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (ctrl_q == '0 && irq_n));

    // R3: control registers change only on a selected write-strobe release
    a_r3_ctrl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(!cs_n && wr_n));

    // R9: interrupt asserts only after an event or a selected access
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(evt_in != '0) || $past(!cs_n)));
endmodule

bind hbi_host_port hbi_host_port_chk #(.CTRL_W(N_CTRL*DATA_W), .EVT_W(EVT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_oe(bus_oe), .evt_in(evt_in), .ctrl_q(ctrl_q), .irq_n(irq_n)
);

// File: tb/hbi_host_port_tb_top.sv
module hbi_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sep = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, as = 1'b0;
    logic [4:0]  addr_in = '0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  evt_in = '0;
    logic [31:0] ctrl_q;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbi_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .as(as), .addr_in(addr_in), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .evt_in(evt_in), .ctrl_q(ctrl_q), .irq_n(irq_n)
    );

    // {do_write, mode_sep, addr, wdata, expected readback}
    localparam logic [25:0] VEC [0:9] = '{
        {1'b1, 1'b1, 8'h00, 8'h5A, 8'h5A},   // R6 ctrl0
        {1'b1, 1'b1, 8'h03, 8'hC3, 8'hC3},   // R6 ctrl3
        {1'b1, 1'b0, 8'h01, 8'h81, 8'h81},   // R2 shared bus
        {1'b1, 1'b0, 8'hE2, 8'h7E, 8'h7E},   // R2 upper bits ignored
        {1'b0, 1'b1, 8'h02, 8'h00, 8'h7E},   // R2 alias reached ctrl2
        {1'b1, 1'b1, 8'h14, 8'hFF, 8'h00},   // R6 unused address
        {1'b0, 1'b0, 8'h1F, 8'h00, 8'h00},   // R6 unused address
        {1'b1, 1'b0, 8'h05, 8'hFF, 8'h00},   // R6 status read-only
        {1'b1, 1'b1, 8'h04, 8'h0F, 8'h0F},   // R6 mask
        {1'b0, 1'b0, 8'h00, 8'h00, 8'h5A}    // R6 ctrl0 via shared bus
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_addr(input logic m, input logic [7:0] a);
        @(negedge clk);
        mode_sep = m;
        if (m) begin
            addr_in = a[4:0];
        end else begin
            bus_in = a;
            as = 1'b1;
            @(negedge clk);
            as = 1'b0;
            bus_in = 8'h00;
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; bus_in = d;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; bus_in = 8'h00;
    endtask

    task automatic do_read(output logic [7:0] v, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        v = bus_out; oe = bus_oe;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic oe;
        repeat (3) @(negedge clk);
        // R5 reset state
        check(ctrl_q == 32'h0 && irq_n == 1'b1 && bus_oe == 1'b0, "R5 reset outputs",
              {ctrl_q[23:0], 6'b0, irq_n, bus_oe}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            set_addr(VEC[i][24], VEC[i][23:16]);
            if (VEC[i][25]) do_write(VEC[i][15:8]);
            do_read(v, oe);
            check(oe == 1'b1 && v == VEC[i][7:0], $sformatf("R6/R2 vector %0d", i), {oe, v}, {1'b1, VEC[i][7:0]});
        end
        check(ctrl_q == 32'hC37E815A, "R6 ctrl_q layout", ctrl_q, 32'hC37E815A);

        // R4: bus released when idle
        #1 check(bus_oe == 1'b0, "R4 idle no drive", bus_oe, 0);

        // R1: strobe ignored in separate-address mode
        set_addr(1'b1, 8'h00);
        @(negedge clk); bus_in = 8'h03; as = 1'b1;
        @(negedge clk); as = 1'b0; bus_in = 8'h00;
        do_read(v, oe);
        check(v == 8'h5A, "R1 strobe ignored", v, 8'h5A);

        // R3: write aborted by early chip-select release
        set_addr(1'b1, 8'h01);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; bus_in = 8'h11;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); wr_n = 1'b1; bus_in = 8'h00;
        do_read(v, oe);
        check(v == 8'h81, "R3 aborted write", v, 8'h81);

        // R3: write strobe without chip select
        @(negedge clk); wr_n = 1'b0; bus_in = 8'h22;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); bus_in = 8'h00;
        check(ctrl_q[15:8] == 8'h81, "R3 no write without select", ctrl_q[15:8], 8'h81);

        // R7/R9: unmasked event raises interrupt
        @(negedge clk); evt_in = 8'h01;
        @(negedge clk); evt_in = 8'h00;
        check(irq_n == 1'b0, "R9 irq on masked-in event", irq_n, 0);
        set_addr(1'b1, 8'h05);
        do_read(v, oe);
        check(v == 8'h01, "R7 status sticky", v, 8'h01);
        @(negedge clk);
        check(irq_n == 1'b1, "R8/R9 cleared after read", irq_n, 1);

        // R9: masked-off event sets status but not interrupt
        @(negedge clk); evt_in = 8'h80;
        @(negedge clk); evt_in = 8'h00;
        check(irq_n == 1'b1, "R9 masked event no irq", irq_n, 1);

        // R8: event in the clearing clock survives
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #1 v = bus_out;
        check(v == 8'h80, "R7 masked bit recorded", v, 8'h80);
        @(negedge clk); rd_n = 1'b1; evt_in = 8'h80;
        @(negedge clk); cs_n = 1'b1; evt_in = 8'h00;
        do_read(v, oe);
        check(v == 8'h80, "R8 event wins over clear", v, 8'h80);
        do_read(v, oe);
        check(v == 8'h00, "R8 cleared on second read", v, 8'h00);

        // R5: reset mid-run clears everything
        @(negedge clk); evt_in = 8'h01;
        @(negedge clk); evt_in = 8'h00; rst_n = 1'b0;
        #1 check(ctrl_q == 32'h0 && irq_n == 1'b1, "R5 reset clears", {ctrl_q[30:0], irq_n}, 32'h1);
        @(negedge clk); rst_n = 1'b1;
        set_addr(1'b1, 8'h04);
        do_read(v, oe);
        check(v == 8'h00, "R5 mask cleared", v, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule